// File: doc/BRIEF.md
# Byte Timing-Failure Fault Emulator

This block sits between an 8-bit substitution stage and the register that captures its result. It imitates what happens when the clock period is shortened below the delay of some output bits. Each incoming byte selects a failure weight from a table, and each stress level has its own table. The output bits are visited in a fixed, programmable slowest-first ranking. The slowest bits are overwritten with pseudo-random bits, and the weight decides how many of them. One more bit is overwritten only with a fractional chance.

A simpler random-AND fault mode is also available. An infective-countermeasure option turns any disturbed result into a wholly fresh random byte.

Bytes move through a valid/ready handshake with one cycle of latency. Each result carries a flag that is high when the emitted byte differs from the correct one. Tables, the bit ranking and the generator seed are loaded through plain configuration ports.

Top module: `tfe_fault_emulator`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and the random state equals 32'h0000_0001.
- R2: The random state is a 32-bit Galois register. Its next value is `s>>1` when `s[0]` is 0, and `(s>>1) ^ 32'h8020_0003` when `s[0]` is 1. It advances exactly once per accepted input. `seed_load` replaces it with `seed_value`, and a zero seed is replaced by 1. A transfer uses the state held when the transfer is accepted, split into four fields: replacement bits [7:0], fraction comparand [15:8], AND mask [23:16] and infective byte [31:24].
- R3: A table entry is 8·P_d in fixed point: whole count W in bits [11:8] and fraction F in bits [7:0]. In timing mode (`mode`=0) the first min(W,8) ranked bits are each replaced by the replacement bit at the same output position.
- R4: An entry of zero makes the output equal the input exactly, with the flag low.
- R5: Field k of `order_map`, bits [3k+2:3k], names the output position of rank k (rank 0 is the slowest). Ranks beyond the replaced ones pass through unchanged.
- R6: When W<8, the bit at rank W is replaced as well exactly when F is greater than the fraction comparand.
- R7: Five tables are held, one per level 0..4, and written through `tbl_we`/`tbl_level`/`tbl_addr`/`tbl_data`. An `in_level` of 5, 6 or 7 selects level 4.
- R8: In random-AND mode (`mode`=1) the output is the input ANDed with the AND mask, so no 0 becomes 1.
- R9: With `infect_en` high, any result that differs from the input is replaced by the infective byte.
- R10: `out_fault` is high exactly when `out_data` differs from the accepted input.
- R11: A result appears on the cycle after acceptance. `in_ready` is `!out_valid || out_ready`. A stalled result holds its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Correct byte from the substitution stage |
| in_level | input | 3 | Stress level |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Possibly corrupted byte |
| out_fault | output | 1 | Result differs from the correct byte |
| mode | input | 1 | 0 timing fault, 1 random-AND |
| infect_en | input | 1 | Infective countermeasure enable |
| order_map | input | 24 | Rank-to-position map, 3 bits per rank |
| seed_load | input | 1 | Load the random state |
| seed_value | input | 32 | Seed |
| tbl_we | input | 1 | Table write strobe |
| tbl_level | input | 3 | Table being written |
| tbl_addr | input | 8 | Input value being written |
| tbl_data | input | 12 | Entry, 8·P_d fixed point |

## Verification
The hardest case to reach is the fractional extra bit. The bit at rank W is replaced only when the fraction beats a comparand taken from the middle byte of the random state. Whether that happens depends on the whole history of accepted transfers since the seed was loaded.

The bench reaches this case by loading known seeds and modelling the generator on its own. It then uses entries whose fraction is 0xFF and whose whole count is 0 or 2. In that setting the comparand is the only thing that decides whether the extra bit flips. The same model also covers a stalled result, where the generator must not advance while the input waits.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    localparam int DATA_W    = 8;
    localparam int RANK_W    = 3;
    localparam int WHOLE_W   = 4;
    localparam int FRAC_W    = 8;
    localparam int PROB_W    = WHOLE_W + FRAC_W;
    localparam int LEVEL_W   = 3;
    localparam int NUM_LEVELS = 5;
    localparam int RND_W     = 32;
    localparam logic [RND_W-1:0] GALOIS_TAPS = 32'h8020_0003;
    localparam logic [RND_W-1:0] SEED_RESET  = 32'h0000_0001;

    typedef enum logic {
        MODE_TIMING   = 1'b0,
        MODE_RAND_AND = 1'b1
    } fault_mode_e;

    typedef struct packed {
        logic [WHOLE_W-1:0] whole;
        logic [FRAC_W-1:0]  frac;
    } prob_t;

    typedef struct packed {
        logic [DATA_W-1:0] infect;
        logic [DATA_W-1:0] and_mask;
        logic [FRAC_W-1:0] cmp;
        logic [DATA_W-1:0] repl;
    } rnd_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fault;
    } result_t;

    function automatic logic [RND_W-1:0] galois_step(input logic [RND_W-1:0] s);
        logic [RND_W-1:0] nxt;
        nxt = s >> 1;
        if (s[0]) nxt = nxt ^ GALOIS_TAPS;
        return nxt;
    endfunction

    function automatic logic [LEVEL_W-1:0] clamp_level(input logic [LEVEL_W-1:0] lv);
        logic [LEVEL_W-1:0] top;
        top = LEVEL_W'(NUM_LEVELS - 1);
        return (lv > top) ? top : lv;
    endfunction

endpackage

// File: rtl/tfe_prob_table.sv
module tfe_prob_table
    import tfe_pkg::*;
#(
    parameter int LEVELS = NUM_LEVELS,
    parameter int DW     = DATA_W
)(
    input  logic               clk,
    input  logic               wr_en,
    input  logic [LEVEL_W-1:0] wr_level,
    input  logic [DW-1:0]      wr_addr,
    input  prob_t              wr_data,
    input  logic [LEVEL_W-1:0] rd_level,
    input  logic [DW-1:0]      rd_addr,
    output prob_t              rd_data
);
    localparam int ENTRIES = 1 << DW;

    prob_t store [LEVELS][ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_level) < LEVELS)) begin
            store[wr_level][wr_addr] <= wr_data;
        end
    end

    logic [LEVEL_W-1:0] lv_sel;
    assign lv_sel  = clamp_level(rd_level);
    assign rd_data = store[lv_sel][rd_addr];

endmodule

// File: rtl/tfe_lfsr.sv
module tfe_lfsr
    import tfe_pkg::*;
#(
    parameter int W = RND_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         advance,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED_RESET;
        end else if (load) begin
            state <= (seed == '0) ? SEED_RESET : seed;
        end else if (advance) begin
            state <= galois_step(state);
        end
    end

    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_step_once_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(state));

endmodule

// File: rtl/tfe_corrupt.sv
module tfe_corrupt
    import tfe_pkg::*;
#(
    parameter int DW = DATA_W
)(
    input  logic [DW-1:0]        data_in,
    input  prob_t                prob,
    input  logic [DW*RANK_W-1:0] order_map,
    input  rnd_t                 rnd,
    input  fault_mode_e          mode,
    input  logic                 infect_en,
    output result_t              result
);
    localparam int CNT_W = WHOLE_W;

    logic [CNT_W-1:0] hit_count;
    logic [DW-1:0]    rank_hit;
    logic [DW-1:0]    pos_mask;
    logic [DW-1:0]    timed;
    logic [DW-1:0]    anded;
    logic [DW-1:0]    pre;
    logic [DW-1:0]    final_byte;

    assign hit_count = (prob.whole > CNT_W'(DW)) ? CNT_W'(DW) : prob.whole;

    for (genvar k = 0; k < DW; k++) begin : g_rank
        assign rank_hit[k] = (CNT_W'(k) < hit_count) ||
                             ((CNT_W'(k) == hit_count) && (prob.frac > rnd.cmp));
    end

    always_comb begin
        pos_mask = '0;
        for (int k = 0; k < DW; k++) begin
            if (rank_hit[k]) pos_mask[order_map[k*RANK_W +: RANK_W]] = 1'b1;
        end
    end

    assign timed = (data_in & ~pos_mask) | (rnd.repl & pos_mask);
    assign anded = data_in & rnd.and_mask;
    assign pre   = (mode == MODE_RAND_AND) ? anded : timed;

    assign final_byte   = (infect_en && (pre != data_in)) ? rnd.infect : pre;
    assign result.data  = final_byte;
    assign result.fault = (final_byte != data_in);

endmodule

// File: rtl/tfe_fault_emulator.sv
module tfe_fault_emulator
    import tfe_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [LEVEL_W-1:0]        in_level,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_fault,
    input  logic                      mode,
    input  logic                      infect_en,
    input  logic [DATA_W*RANK_W-1:0]  order_map,
    input  logic                      seed_load,
    input  logic [RND_W-1:0]          seed_value,
    input  logic                      tbl_we,
    input  logic [LEVEL_W-1:0]        tbl_level,
    input  logic [DATA_W-1:0]         tbl_addr,
    input  logic [PROB_W-1:0]         tbl_data
);
    logic        accept;
    prob_t       prob_rd;
    logic [RND_W-1:0] rnd_state;
    rnd_t        rnd_fields;
    result_t     res_next;
    result_t     res_q;
    fault_mode_e mode_e;

    assign in_ready   = !out_valid || out_ready;
    assign accept     = in_valid && in_ready;
    assign rnd_fields = rnd_t'(rnd_state);
    assign mode_e     = fault_mode_e'(mode);

    tfe_prob_table #(.LEVELS(NUM_LEVELS), .DW(DATA_W)) u_table (
        .clk      (clk),
        .wr_en    (tbl_we),
        .wr_level (tbl_level),
        .wr_addr  (tbl_addr),
        .wr_data  (prob_t'(tbl_data)),
        .rd_level (in_level),
        .rd_addr  (in_data),
        .rd_data  (prob_rd)
    );

    tfe_lfsr #(.W(RND_W)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_load),
        .seed    (seed_value),
        .advance (accept),
        .state   (rnd_state)
    );

    tfe_corrupt #(.DW(DATA_W)) u_corrupt (
        .data_in   (in_data),
        .prob      (prob_rd),
        .order_map (order_map),
        .rnd       (rnd_fields),
        .mode      (mode_e),
        .infect_en (infect_en),
        .result    (res_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            res_q     <= res_next;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_data  = res_q.data;
    assign out_fault = res_q.fault;

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fault)));

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    assert_zero_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && prob_rd == '0 && mode == 1'b0) |=> (out_data == $past(in_data) && !out_fault));

    assert_and_no_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == 1'b1 && !infect_en) |=> ((out_data & ~$past(in_data)) == '0));

endmodule

// File: tb/test_tfe_fault_emulator.sv
module test_tfe_fault_emulator;
    import tfe_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, out_valid, out_ready, out_fault;
    logic [7:0] in_data, out_data;
    logic [2:0] in_level;
    logic mode, infect_en, seed_load, tbl_we;
    logic [23:0] order_map;
    logic [31:0] seed_value;
    logic [2:0] tbl_level;
    logic [7:0] tbl_addr;
    logic [11:0] tbl_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] mdl;
    logic [11:0] shadow [5][256];

    always #2 clk = ~clk;

    tfe_fault_emulator i_tfe_fault_emulator (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_level(in_level), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_fault(out_fault),
        .mode(mode), .infect_en(infect_en), .order_map(order_map),
        .seed_load(seed_load), .seed_value(seed_value), .tbl_we(tbl_we),
        .tbl_level(tbl_level), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic logic [7:0] ref_out(input logic [7:0] d, input logic [11:0] p,
                                           input logic md, input logic inf,
                                           input logic [31:0] s, input logic [23:0] om);
        int w;
        logic [7:0] r;
        r = d;
        if (md) begin
            r = d & s[23:16];
        end else begin
            w = int'(p[11:8]);
            if (w > 8) w = 8;
            for (int k = 0; k < 8; k++) begin
                int pos;
                pos = int'(om[3*k +: 3]);
                if (k < w || (k == w && p[7:0] > s[15:8])) r[pos] = s[pos];
            end
        end
        if (inf && r != d) r = s[31:24];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_tbl(input int lv, input int a, input logic [11:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_level = 3'(lv); tbl_addr = 8'(a); tbl_data = v;
        @(negedge clk);
        tbl_we = 1'b0;
        if (lv < 5) shadow[lv][a] = v;
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed_load = 1'b1; seed_value = s;
        @(negedge clk);
        seed_load = 1'b0;
        mdl = (s == 0) ? 32'h1 : s;
    endtask

    task automatic xfer(input logic [7:0] d, input logic [2:0] lv, input string req);
        logic [7:0] e;
        int lvc;
        lvc = (lv > 4) ? 4 : int'(lv);
        e = ref_out(d, shadow[lvc][d], mode, infect_en, mdl, order_map);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_level = lv;
        @(negedge clk);
        in_valid = 1'b0;
        mdl = ref_next(mdl);
        chk(out_valid == 1'b1, req, 32'(out_valid), 32'd1);
        chk(out_data == e, req, 32'(out_data), 32'(e));
        chk(out_fault == (e != d), "R10", 32'(out_fault), 32'(e != d));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", 32'(in_ready), 1);
    endtask

    task automatic t_zero;
        mdl = 32'h1;
        xfer(8'h3C, 3'd0, "R4");
        xfer(8'hFF, 3'd0, "R4");
        xfer(8'h00, 3'd0, "R4");
    endtask

    task automatic t_full;
        load_seed(32'hDEAD_BEEF);
        wr_tbl(1, 8'h5A, 12'h800);
        wr_tbl(1, 8'hA5, 12'h9FF);
        for (int i = 0; i < 4; i++) xfer(8'h5A, 3'd1, "R3");
        xfer(8'hA5, 3'd1, "R3");
    endtask

    task automatic t_partial;
        order_map = {3'd4, 3'd5, 3'd2, 3'd7, 3'd0, 3'd6, 3'd1, 3'd3};
        load_seed(32'h1234_5678);
        wr_tbl(2, 8'hC3, 12'h300);
        for (int i = 0; i < 4; i++) xfer(8'hC3, 3'd2, "R5");
    endtask

    task automatic t_frac;
        load_seed(32'h0BAD_F00D);
        wr_tbl(0, 8'h11, 12'h0FF);
        wr_tbl(0, 8'h22, 12'h2FF);
        for (int i = 0; i < 6; i++) xfer(8'h11, 3'd0, "R6");
        for (int i = 0; i < 6; i++) xfer(8'h22, 3'd0, "R6");
    endtask

    task automatic t_level;
        wr_tbl(3, 8'h77, 12'h000);
        wr_tbl(4, 8'h77, 12'h800);
        load_seed(32'hCAFE_0001);
        xfer(8'h77, 3'd3, "R7");
        xfer(8'h77, 3'd4, "R7");
        xfer(8'h77, 3'd6, "R7");
        xfer(8'h77, 3'd7, "R7");
    endtask

    task automatic t_and;
        mode = 1'b1;
        load_seed(32'h5555_AAAA);
        for (int i = 0; i < 4; i++) xfer(8'hF0 ^ 8'(i * 17), 3'd0, "R8");
        mode = 1'b0;
    endtask

    task automatic t_infect;
        infect_en = 1'b1;
        load_seed(32'h0F0F_1234);
        for (int i = 0; i < 3; i++) xfer(8'h5A, 3'd1, "R9");
        xfer(8'h3C, 3'd0, "R9");
        mode = 1'b1;
        xfer(8'hEE, 3'd0, "R9");
        mode = 1'b0;
        infect_en = 1'b0;
    endtask

    task automatic t_seed;
        load_seed(32'h0);
        chk(mdl == 32'h1, "R2", mdl, 32'h1);
        xfer(8'h5A, 3'd1, "R2");
        xfer(8'h5A, 3'd1, "R2");
    endtask

    task automatic t_stall;
        logic [7:0] e1, e2;
        load_seed(32'h8765_4321);
        e1 = ref_out(8'h5A, shadow[1][8'h5A], 1'b0, 1'b0, mdl, order_map);
        mdl = ref_next(mdl);
        e2 = ref_out(8'hA5, shadow[1][8'hA5], 1'b0, 1'b0, mdl, order_map);
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h5A; in_level = 3'd1;
        @(negedge clk);
        in_data = 8'hA5;
        chk(out_valid == 1'b1, "R11", 32'(out_valid), 1);
        chk(out_data == e1, "R11", 32'(out_data), 32'(e1));
        chk(in_ready == 1'b0, "R11", 32'(in_ready), 0);
        @(negedge clk);
        @(negedge clk);
        chk(out_data == e1, "R11", 32'(out_data), 32'(e1));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        mdl = ref_next(mdl);
        chk(out_valid == 1'b1, "R11", 32'(out_valid), 1);
        chk(out_data == e2, "R2", 32'(out_data), 32'(e2));
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", 32'(out_valid), 0);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_level = '0; out_ready = 1'b1;
        mode = 1'b0; infect_en = 1'b0; seed_load = 1'b0; seed_value = '0;
        tbl_we = 1'b0; tbl_level = '0; tbl_addr = '0; tbl_data = '0;
        order_map = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        mdl = 32'h1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        for (int lv = 0; lv < 5; lv++)
            for (int a = 0; a < 256; a++) wr_tbl(lv, a, 12'h000);
        t_zero();
        t_full();
        t_partial();
        t_frac();
        t_level();
        t_and();
        t_infect();
        t_seed();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule